// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

The block collects five interrupt sources for a small 8-bit CPU core: two active-low external request pins, two timer overflow events and one serial request. It holds the capture flags for the external pins and the timers, an enable register with a master switch, a priority register and a trigger-type register. From these it raises one request to the CPU, together with the handler address and the priority level of the chosen source.

The CPU answers with an acknowledge pulse when it vectors to the handler. The acknowledge clears the flag of the chosen source where hardware owns that flag, and marks the source's level as in service. A return pulse ends the most recent service.

A high-priority source can interrupt a low-priority handler. Nothing can interrupt a handler at its own level or at a higher level. The external pins are sampled once per machine cycle, on a strobe from the core.

Top module: `irqc_top`

## Requirements
- R1: Sources have fixed indices: ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4. The handler address on `irq_vec` is 0003h + 8×index, so the addresses are 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R2: `irq_req` is 0 while the master enable is 0, whatever is pending. While the master enable is 1, a source can only be chosen if its own enable bit is 1.
- R3: A priority bit of 1 marks the source as high. A pending, enabled high source is always chosen over any low source, and `irq_hi` shows the level of the chosen source.
- R4: Among candidates of the same level, the lowest index wins.
- R5: An external pin in edge mode is sampled only on cycles with `mc_tick`=1. A sample of 1 followed by a sample of 0 sets its flag. A pin that stays low, or a change that no tick samples, sets nothing.
- R6: An external pin in level mode is pending exactly while its last tick sample is 0. It has no latch, so it remains pending after an acknowledge.
- R7: An acknowledge clears the flag of the chosen source if that source is a timer or an edge-mode external pin. A new set event in the same cycle takes precedence over the clear.
- R8: The serial request is the OR of `ser_rx_flag` and `ser_tx_flag`, and an acknowledge does not change it.
- R9: An acknowledge marks the chosen level as in service on `in_service` (bit1 = high, bit0 = low). A return clears the highest marked level. While bit1 is set no request is raised. While only bit0 is set, only high sources are raised.
- R10: Writes go through `reg_wr` and `reg_sel`. Select 0 sets the enables: bit7 is the master enable and bits 4..0 are the per-source enables by index. Select 1 sets the priority bits 4..0 by index. Select 2 sets the trigger type: bit0 for ext0 and bit1 for ext1, with 1 meaning edge. Select 3 is ignored. A write takes effect at the next clock edge.
- R11: After reset, all registers and flags are 0, the external pins are in level mode, the pin samples read 1, and `irq_req`, `in_service` and `pend_flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe that samples the external pins |
| ext_pin_n | input | 2 | Active-low external request pins (bit k = ext k) |
| tmr_ovf | input | 2 | One-cycle timer overflow events (bit k = timer k) |
| ser_rx_flag | input | 1 | Receive-done flag from the serial logic |
| ser_tx_flag | input | 1 | Transmit-done flag from the serial logic |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| irq_ack | input | 1 | CPU vectors to the offered handler |
| irq_reti | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | Request to the CPU |
| irq_hi | output | 1 | Level of the offered source |
| irq_vec | output | 16 | Handler address of the offered source |
| in_service | output | 2 | In-service marks (bit1 = high, bit0 = low) |
| pend_flags | output | 5 | Pending state of each source, by index |

## Verification
Every stored item takes one clock edge to change: a tick sample, an edge flag, a timer flag, a register write, an acknowledge and a return. The request, level and address outputs are combinational from that state, so each result can be read at the first falling edge after the edge that latches the stimulus. The bench drives every stimulus just after a falling edge and compares at the next falling edge, one rising edge later. The sweeps walk all 32 priority masks and all 32 enable masks with every source pending, and the expected winner is computed from the lowest set index.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_PRIO   = 2'd1,
        SEL_TYPE   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic smp;
        logic flag;
    } pin_state_t;

endpackage

// File: rtl/irqc_pin_capture.sv
module irqc_pin_capture
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic pin_n,
    input  logic edge_md,
    input  logic clr,
    output logic pend
);

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flag = 1'b0;
        end
        if (mc_tick) begin
            st_d.smp = pin_n;
            if (edge_md && st_q.smp && !pin_n) begin
                st_d.flag = 1'b1;
            end
        end
        if (!edge_md) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{smp: 1'b1, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = edge_md ? st_q.flag : !st_q.smp;

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
    parameter int SRC_N = 5,
    parameter int IDX_W = 3
) (
    input  logic [SRC_N-1:0] armed,
    input  logic [SRC_N-1:0] hi_mask,
    input  logic [1:0]       svc,
    output logic             ok,
    output logic             lvl_hi,
    output logic [IDX_W-1:0] idx
);

    logic             hi_any_d, lo_any_d;
    logic [IDX_W-1:0] hi_idx_d, lo_idx_d;

    always_comb begin
        hi_any_d = 1'b0;
        lo_any_d = 1'b0;
        hi_idx_d = '0;
        lo_idx_d = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (armed[i] && hi_mask[i]) begin
                hi_any_d = 1'b1;
                hi_idx_d = IDX_W'(i);
            end
            if (armed[i] && !hi_mask[i]) begin
                lo_any_d = 1'b1;
                lo_idx_d = IDX_W'(i);
            end
        end
    end

    always_comb begin
        ok     = 1'b0;
        lvl_hi = 1'b0;
        idx    = '0;
        if (hi_any_d && !svc[1]) begin
            ok     = 1'b1;
            lvl_hi = 1'b1;
            idx    = hi_idx_d;
        end else if (lo_any_d && (svc == 2'b00)) begin
            ok     = 1'b1;
            idx    = lo_idx_d;
        end
    end

endmodule

// File: rtl/irqc_svc_stack.sv
module irqc_svc_stack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       push_hi,
    input  logic       pop,
    output logic [1:0] svc
);

    logic [1:0] svc_d, svc_q;

    always_comb begin
        svc_d = svc_q;
        if (pop) begin
            if (svc_q[1]) begin
                svc_d[1] = 1'b0;
            end else begin
                svc_d[0] = 1'b0;
            end
        end
        if (push) begin
            svc_d[push_hi] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_q <= 2'b00;
        end else begin
            svc_q <= svc_d;
        end
    end

    assign svc = svc_q;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int REG_W     = 8,
    parameter int VEC_W     = 16,
    parameter int VEC_BASE  = 3,
    parameter int VEC_STEP  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mc_tick,
    input  logic [NUM_PAIRS-1:0]   ext_pin_n,
    input  logic [NUM_PAIRS-1:0]   tmr_ovf,
    input  logic                   ser_rx_flag,
    input  logic                   ser_tx_flag,
    input  logic                   reg_wr,
    input  logic [1:0]             reg_sel,
    input  logic [REG_W-1:0]       reg_wdata,
    input  logic                   irq_ack,
    input  logic                   irq_reti,
    output logic                   irq_req,
    output logic                   irq_hi,
    output logic [VEC_W-1:0]       irq_vec,
    output logic [1:0]             in_service,
    output logic [2*NUM_PAIRS:0]   pend_flags
);

    localparam int SRC_N   = 2 * NUM_PAIRS + 1;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int SER_IDX = SRC_N - 1;

    typedef struct packed {
        logic                 glb;
        logic [SRC_N-1:0]     en;
        logic [SRC_N-1:0]     hi;
        logic [NUM_PAIRS-1:0] edge_md;
        logic [NUM_PAIRS-1:0] tflag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [SRC_N-1:0]     pend;
    logic [SRC_N-1:0]     armed;
    logic [SRC_N-1:0]     clr;
    logic [NUM_PAIRS-1:0] ext_pend;
    logic                 sel_ok;
    logic                 sel_hi;
    logic [IDX_W-1:0]     sel_idx;
    logic                 ack_fire;
    logic                 glb_on;
    logic [1:0]           svc;

    genvar k;
    generate
        for (k = 0; k < NUM_PAIRS; k++) begin : g_pair
            irqc_pin_capture u_pin (
                .clk     (clk),
                .rst_n   (rst_n),
                .mc_tick (mc_tick),
                .pin_n   (ext_pin_n[k]),
                .edge_md (ctl_q.edge_md[k]),
                .clr     (clr[2*k]),
                .pend    (ext_pend[k])
            );
            assign pend[2*k]   = ext_pend[k];
            assign pend[2*k+1] = ctl_q.tflag[k];
        end
    endgenerate

    assign pend[SER_IDX] = ser_rx_flag | ser_tx_flag;
    assign armed         = pend & ctl_q.en & {SRC_N{ctl_q.glb}};
    assign glb_on        = ctl_q.glb;

    irqc_select #(
        .SRC_N (SRC_N),
        .IDX_W (IDX_W)
    ) u_sel (
        .armed   (armed),
        .hi_mask (ctl_q.hi),
        .svc     (svc),
        .ok      (sel_ok),
        .lvl_hi  (sel_hi),
        .idx     (sel_idx)
    );

    assign ack_fire = irq_ack && sel_ok;
    assign clr      = ack_fire ? (SRC_N'(1) << sel_idx) : '0;

    irqc_svc_stack u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ack_fire),
        .push_hi (sel_hi),
        .pop     (irq_reti),
        .svc     (svc)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_ENABLE: begin
                    ctl_d.glb = reg_wdata[REG_W-1];
                    ctl_d.en  = reg_wdata[SRC_N-1:0];
                end
                SEL_PRIO: ctl_d.hi      = reg_wdata[SRC_N-1:0];
                SEL_TYPE: ctl_d.edge_md = reg_wdata[NUM_PAIRS-1:0];
                default: ;
            endcase
        end
        for (int t = 0; t < NUM_PAIRS; t++) begin
            if (clr[2*t+1]) begin
                ctl_d.tflag[t] = 1'b0;
            end
            if (tmr_ovf[t]) begin
                ctl_d.tflag[t] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_req    = sel_ok;
    assign irq_hi     = sel_ok && sel_hi;
    assign irq_vec    = sel_ok ? (VEC_W'(VEC_BASE) + VEC_W'(sel_idx) * VEC_W'(VEC_STEP))
                               : '0;
    assign in_service = svc;
    assign pend_flags = pend;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int VEC_W    = 16,
    parameter int SRC_N    = 5,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             irq_hi,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack,
    input logic             irq_reti,
    input logic [1:0]       in_service,
    input logic [SRC_N-1:0] pend_flags,
    input logic             tmr0_ovf,
    input logic             glb_on
);

    localparam logic [VEC_W-1:0] TMR0_VEC = VEC_W'(VEC_BASE + VEC_STEP);
    localparam logic [VEC_W-1:0] VEC_END  = VEC_W'(VEC_BASE + VEC_STEP * SRC_N);

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> glb_on); // R2

    AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'd3) && (irq_vec < VEC_END)); // R1

    AST_HIGH_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        in_service[1] |-> !irq_req); // R9

    AST_LOW_ADMITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service[0] && irq_req) |-> irq_hi); // R9

    AST_PUSH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && irq_hi && !irq_reti) |=> in_service[1]); // R9

    AST_TMR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && (irq_vec == TMR0_VEC) && !tmr0_ovf) |=> !pend_flags[1]); // R7

endmodule

bind irqc_top irqc_checker #(
    .VEC_W    (VEC_W),
    .SRC_N    (SRC_N),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_hi     (irq_hi),
    .irq_vec    (irq_vec),
    .irq_ack    (irq_ack),
    .irq_reti   (irq_reti),
    .in_service (in_service),
    .pend_flags (pend_flags),
    .tmr0_ovf   (tmr_ovf[0]),
    .glb_on     (glb_on)
);

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/100ps
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_rx_flag = 1'b0;
    logic        ser_tx_flag = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic        irq_ack = 1'b0;
    logic        irq_reti = 1'b0;
    logic        irq_req;
    logic        irq_hi;
    logic [15:0] irq_vec;
    logic [1:0]  in_service;
    logic [4:0]  pend_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irqc_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_tick     (mc_tick),
        .ext_pin_n   (ext_pin_n),
        .tmr_ovf     (tmr_ovf),
        .ser_rx_flag (ser_rx_flag),
        .ser_tx_flag (ser_tx_flag),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .irq_ack     (irq_ack),
        .irq_reti    (irq_reti),
        .irq_req     (irq_req),
        .irq_hi      (irq_hi),
        .irq_vec     (irq_vec),
        .in_service  (in_service),
        .pend_flags  (pend_flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic tick();
        mc_tick = 1'b1; cyc(); mc_tick = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
    endtask

    task automatic reti();
        irq_reti = 1'b1; cyc(); irq_reti = 1'b0;
    endtask

    function automatic int first_bit(input logic [4:0] m);
        for (int i = 4; i >= 0; i--) begin
            if (m[i]) first_bit = i;
        end
        if (m == 5'd0) first_bit = 0;
    endfunction

    function automatic logic [15:0] vec_of(input int idx);
        return 16'(3 + 8 * idx);
    endfunction

    initial begin : wd
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R11 reset state
        chk("R11 req", irq_req, 0);
        chk("R11 svc", in_service, 0);
        chk("R11 pend", pend_flags, 0);

        // R6 level pins low; R8 serial; timers set
        ext_pin_n = 2'b00; tick();
        tmr_ovf = 2'b11; cyc(); tmr_ovf = 2'b00;
        ser_rx_flag = 1'b1; cyc();
        chk("R6 R8 pend all", pend_flags, 5'h1F);
        chk("R2 global off", irq_req, 0);

        // R3 R4 priority sweep, R10 select 0/1
        wr(2'd0, 8'h9F);
        for (int p = 0; p < 32; p++) begin
            wr(2'd1, 8'(p));
            chk("R3 R4 req", irq_req, 1);
            chk("R3 R4 vec", irq_vec, vec_of(first_bit(5'(p))));
            chk("R3 hi", irq_hi, (p != 0));
        end
        // R2 enable sweep
        wr(2'd1, 8'h00);
        for (int e = 0; e < 32; e++) begin
            wr(2'd0, 8'h80 | 8'(e));
            chk("R2 req", irq_req, (e != 0));
            if (e != 0) chk("R2 R1 vec", irq_vec, vec_of(first_bit(5'(e))));
        end
        wr(2'd0, 8'h1F);
        chk("R2 master off", irq_req, 0);
        wr(2'd3, 8'hFF);
        chk("R10 sel3 ignored", irq_req, 0);

        // R9 in-service and preemption
        wr(2'd0, 8'h9F);
        chk("R1 ext0 vec", irq_vec, 16'h0003);
        ack();
        chk("R9 push low", in_service, 2'b01);
        chk("R6 level stays", pend_flags[0], 1);
        chk("R9 low blocks low", irq_req, 0);
        wr(2'd1, 8'h08);
        chk("R9 preempt req", irq_req, 1);
        chk("R9 preempt hi", irq_hi, 1);
        chk("R1 tmr1 vec", irq_vec, 16'h001B);
        ack();
        chk("R9 push high", in_service, 2'b11);
        chk("R7 tmr1 cleared", pend_flags[3], 0);
        tmr_ovf = 2'b10; cyc(); tmr_ovf = 2'b00;
        chk("R9 high blocks", irq_req, 0);
        reti();
        chk("R9 pop high", in_service, 2'b01);
        chk("R9 high again", irq_vec, 16'h001B);
        ack();
        reti();
        chk("R9 low only", irq_req, 0);
        reti();
        chk("R9 empty", in_service, 2'b00);
        chk("R6 ext0 again", irq_vec, 16'h0003);

        // R8 serial not cleared
        wr(2'd0, 8'h90);
        chk("R1 ser vec", irq_vec, 16'h0023);
        ack();
        chk("R8 ser kept", pend_flags[4], 1);
        ser_rx_flag = 1'b0; ser_tx_flag = 1'b1; cyc();
        chk("R8 tx", pend_flags[4], 1);
        ser_tx_flag = 1'b0; cyc();
        chk("R8 none", pend_flags[4], 0);
        reti();

        // R7 timer0 clear
        wr(2'd0, 8'h82);
        chk("R1 tmr0 vec", irq_vec, 16'h000B);
        ack();
        chk("R7 tmr0 cleared", pend_flags[1], 0);
        chk("R7 no req", irq_req, 0);
        reti();

        // R5 edge mode on ext0
        ext_pin_n = 2'b11; tick();
        chk("R6 released", pend_flags[2], 0);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h81);
        chk("R5 idle", pend_flags[0], 0);
        ext_pin_n[0] = 1'b0; cyc(); cyc();
        chk("R5 no tick", pend_flags[0], 0);
        tick();
        chk("R5 edge", pend_flags[0], 1);
        chk("R5 vec", irq_vec, 16'h0003);
        ack();
        chk("R7 edge cleared", pend_flags[0], 0);
        tick();
        chk("R5 held low", pend_flags[0], 0);
        reti();
        ext_pin_n[0] = 1'b1; tick();
        ext_pin_n[0] = 1'b0; tick();
        chk("R5 second edge", pend_flags[0], 1);

        // R6 level ext1 follows samples
        ext_pin_n[1] = 1'b0; tick();
        chk("R6 ext1 low", pend_flags[2], 1);
        ext_pin_n[1] = 1'b1; tick();
        chk("R6 ext1 high", pend_flags[2], 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule